// File: doc/BRIEF.md
# Decode Operand Bypass and Load-Use Interlock

This block sits in the decode stage of an in-order five-stage pipeline. For each of the two source operands of the instruction in decode it picks the freshest value: the result held by the execute stage, the memory stage or the writeback stage, or the value read from the register file. A stage can supply a value only if it holds a valid instruction that writes a register whose number matches the source. Register number zero never matches. A source the instruction does not use never matches. When more than one stage matches, the youngest one wins.

Forwarding ends in decode, so a branch resolved in decode compares bypassed values. The one case that cannot be bypassed is a load still in execute, because its data does not exist yet. When a used source depends on such a load, the block drops the decode ready_go and holds it low until the load moves on. If the decode instruction is a branch, the block also raises a branch-stall flag for the fetch side, telling it that the branch target is not settled. The block is purely combinational and uses no clock.

Top module: `decode_bypass`

## Requirements
- R1: When no stage matches a source, that operand output equals the matching register-file read data.
- R2: An execute-stage match has the highest priority. It supplies ex_result even when the memory and writeback stages also match the same register.
- R3: When only the memory and writeback stages match a source, the operand equals mem_result (the younger producer wins).
- R4: When only the writeback stage matches a source, the operand equals wb_result.
- R5: A source register number of 0 never matches any stage. Its operand equals the register-file data and it never causes a stall.
- R6: A stage with its valid bit low, or with its write flag low, never matches. This holds even when its destination equals the source.
- R7: A source whose use flag is low passes the register-file data through unchanged and never causes a stall.
- R8: ready_go is 0 exactly when a valid, register-writing load in execute matches a used, nonzero source. A load in the memory stage is forwarded (mem_result) and does not stall.
- R9: br_stall is 1 exactly when ready_go is 0 and id_is_branch is 1.
- R10: The two operands are resolved independently. Each can be served by a different stage in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs1_idx | input | AW | Source 1 register number |
| rs1_use | input | 1 | Decode instruction reads source 1 |
| rs2_idx | input | AW | Source 2 register number |
| rs2_use | input | 1 | Decode instruction reads source 2 |
| rf_rdata1 | input | XLEN | Register-file read port 1 data |
| rf_rdata2 | input | XLEN | Register-file read port 2 data |
| id_is_branch | input | 1 | Decode instruction is a branch or jump resolved in decode |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_dest | input | AW | Execute destination register |
| ex_result | input | XLEN | Execute result (ALU output) |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_wen | input | 1 | Memory instruction writes a register |
| mem_dest | input | AW | Memory destination register |
| mem_result | input | XLEN | Memory result, already chosen between load data and the saved ALU value |
| wb_valid | input | 1 | Writeback stage holds an instruction |
| wb_wen | input | 1 | Writeback instruction writes a register |
| wb_dest | input | AW | Writeback destination register |
| wb_result | input | XLEN | Writeback value |
| opnd1 | output | XLEN | Resolved source 1 value |
| opnd2 | output | XLEN | Resolved source 2 value |
| id_ready_go | output | 1 | Decode may hand its instruction on |
| br_stall | output | 1 | Branch target in decode is not yet computable |

## Verification
A wrong match or priority decision shows up at once, in the same cycle, as an operand carrying the value of the wrong stage. The bench therefore gives every stage and each register-file port a distinct value, so any misrouting shows as a mismatch. A wrong interlock decision shows as ready_go being low with no load in execute, or high while a load match is present. The bench covers both, and checks br_stall against ready_go on branch and non-branch instructions. Register zero, unused sources and invalid or non-writing stages are checked with destinations that would otherwise match, so a missing qualifier shows as a changed operand or a false stall.

// File: rtl/decode_bypass_pkg.sv
package decode_bypass_pkg;
   // forwarding sources in priority order, youngest first
   typedef enum logic [1:0] {
      SRC_EX  = 2'd0,
      SRC_MEM = 2'd1,
      SRC_WB  = 2'd2,
      SRC_RF  = 2'd3
   } fwd_src_e;

   localparam int unsigned NUM_PRODUCERS = 3;
   localparam int unsigned NUM_OPERANDS  = 2;
endpackage

// File: rtl/dbp_hit_detect.sv
// Decides whether one producing stage can feed one decode source.
module dbp_hit_detect #(
   parameter int unsigned AW = 5
) (
   input  logic          src_use,
   input  logic [AW-1:0] src_idx,
   input  logic          prod_valid,
   input  logic          prod_wen,
   input  logic [AW-1:0] prod_dest,
   output logic          hit
);
   logic src_live;
   logic prod_live;

   assign src_live  = src_use && (src_idx != '0);
   assign prod_live = prod_valid && prod_wen;
   assign hit       = src_live && prod_live && (src_idx == prod_dest);

   always_comb begin
      // R5: register zero must never produce a hit
      p_zero_never_hits_r5: assert (!(hit && src_idx == '0));
      // R6: a non-writing or empty stage must never produce a hit
      p_dead_stage_no_hit_r6: assert (!(hit && !(prod_valid && prod_wen)));
   end
endmodule

// File: rtl/dbp_prio_sel.sv
// Four-way priority selector: execute > memory > writeback > register file.
module dbp_prio_sel
   import decode_bypass_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter bit          ONEHOT_MUX = 1'b1
) (
   input  logic [NUM_PRODUCERS-1:0] hits,
   input  logic [XLEN-1:0]          ex_val,
   input  logic [XLEN-1:0]          mem_val,
   input  logic [XLEN-1:0]          wb_val,
   input  logic [XLEN-1:0]          rf_val,
   output logic [XLEN-1:0]          dout,
   output fwd_src_e                 src
);
   localparam int unsigned NUM_INPUTS = NUM_PRODUCERS + 1;

   logic [NUM_INPUTS-1:0] grant;

   always_comb begin
      grant = '0;
      if (hits[SRC_EX])       grant[SRC_EX]  = 1'b1;
      else if (hits[SRC_MEM]) grant[SRC_MEM] = 1'b1;
      else if (hits[SRC_WB])  grant[SRC_WB]  = 1'b1;
      else                    grant[SRC_RF]  = 1'b1;
   end

   always_comb begin
      unique case (1'b1)
         grant[SRC_EX]:  src = SRC_EX;
         grant[SRC_MEM]: src = SRC_MEM;
         grant[SRC_WB]:  src = SRC_WB;
         default:        src = SRC_RF;
      endcase
   end

   generate
      if (ONEHOT_MUX) begin : g_andor
         // flat AND-OR of grant-qualified inputs: one gate level after grant
         always_comb begin
            dout = ({XLEN{grant[SRC_EX]}}  & ex_val)
                 | ({XLEN{grant[SRC_MEM]}} & mem_val)
                 | ({XLEN{grant[SRC_WB]}}  & wb_val)
                 | ({XLEN{grant[SRC_RF]}}  & rf_val);
         end
      end else begin : g_chain
         // cascaded 2:1 stages, register file at the tail
         logic [XLEN-1:0] after_wb;
         logic [XLEN-1:0] after_mem;
         assign after_wb  = hits[SRC_WB]  ? wb_val  : rf_val;
         assign after_mem = hits[SRC_MEM] ? mem_val : after_wb;
         assign dout      = hits[SRC_EX]  ? ex_val  : after_mem;
      end
   endgenerate

   always_comb begin
      // R2: exactly one source is granted
      p_grant_onehot_r2: assert ($onehot(grant));
      // R1: with no hit, the register-file value must come out
      p_nohit_passthru_r1: assert (hits != '0 || dout == rf_val);
   end
endmodule

// File: rtl/dbp_interlock.sv
// Load-use interlock and branch-stall generation.
module dbp_interlock
   import decode_bypass_pkg::*;
(
   input  logic [NUM_OPERANDS-1:0] ex_hit,
   input  logic                    ex_is_load,
   input  logic                    id_is_branch,
   output logic                    ready_go,
   output logic                    br_stall
);
   logic load_use;

   assign load_use = ex_is_load && (|ex_hit);
   assign ready_go = !load_use;
   assign br_stall = load_use && id_is_branch;

   always_comb begin
      // R8: a stall needs a load in execute feeding a source
      p_stall_needs_load_r8: assert (ready_go || (ex_is_load && ex_hit != '0));
      // R9: branch stall only on a stalled branch
      p_brstall_on_branch_r9: assert (!br_stall || (id_is_branch && !ready_go));
   end
endmodule

// File: rtl/decode_bypass.sv
module decode_bypass
   import decode_bypass_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned AW         = 5,
   parameter bit          ONEHOT_MUX = 1'b1
) (
   input  logic [AW-1:0]   rs1_idx,
   input  logic            rs1_use,
   input  logic [AW-1:0]   rs2_idx,
   input  logic            rs2_use,
   input  logic [XLEN-1:0] rf_rdata1,
   input  logic [XLEN-1:0] rf_rdata2,
   input  logic            id_is_branch,
   input  logic            ex_valid,
   input  logic            ex_wen,
   input  logic            ex_is_load,
   input  logic [AW-1:0]   ex_dest,
   input  logic [XLEN-1:0] ex_result,
   input  logic            mem_valid,
   input  logic            mem_wen,
   input  logic [AW-1:0]   mem_dest,
   input  logic [XLEN-1:0] mem_result,
   input  logic            wb_valid,
   input  logic            wb_wen,
   input  logic [AW-1:0]   wb_dest,
   input  logic [XLEN-1:0] wb_result,
   output logic [XLEN-1:0] opnd1,
   output logic [XLEN-1:0] opnd2,
   output logic            id_ready_go,
   output logic            br_stall
);
   generate
      if (XLEN < 1) begin : g_bad_xlen
         $error("decode_bypass: XLEN must be at least 1");
      end
      if (AW < 1 || AW > 8) begin : g_bad_aw
         $error("decode_bypass: AW must lie in 1..8");
      end
   endgenerate

   logic [AW-1:0]   src_idx [NUM_OPERANDS];
   logic            src_use [NUM_OPERANDS];
   logic [XLEN-1:0] rf_val  [NUM_OPERANDS];
   logic [XLEN-1:0] opnd    [NUM_OPERANDS];
   fwd_src_e        opnd_src[NUM_OPERANDS];

   logic            p_valid [NUM_PRODUCERS];
   logic            p_wen   [NUM_PRODUCERS];
   logic [AW-1:0]   p_dest  [NUM_PRODUCERS];

   logic [NUM_PRODUCERS-1:0] hits [NUM_OPERANDS];
   logic [NUM_OPERANDS-1:0]  ex_hit;

   assign src_idx[0] = rs1_idx;   assign src_use[0] = rs1_use;   assign rf_val[0] = rf_rdata1;
   assign src_idx[1] = rs2_idx;   assign src_use[1] = rs2_use;   assign rf_val[1] = rf_rdata2;

   assign p_valid[SRC_EX]  = ex_valid;  assign p_wen[SRC_EX]  = ex_wen;  assign p_dest[SRC_EX]  = ex_dest;
   assign p_valid[SRC_MEM] = mem_valid; assign p_wen[SRC_MEM] = mem_wen; assign p_dest[SRC_MEM] = mem_dest;
   assign p_valid[SRC_WB]  = wb_valid;  assign p_wen[SRC_WB]  = wb_wen;  assign p_dest[SRC_WB]  = wb_dest;

   for (genvar s = 0; s < NUM_OPERANDS; s++) begin : g_opnd
      for (genvar p = 0; p < NUM_PRODUCERS; p++) begin : g_prod
         dbp_hit_detect #(.AW(AW)) u_hit (
            .src_use   (src_use[s]),
            .src_idx   (src_idx[s]),
            .prod_valid(p_valid[p]),
            .prod_wen  (p_wen[p]),
            .prod_dest (p_dest[p]),
            .hit       (hits[s][p])
         );
      end

      dbp_prio_sel #(.XLEN(XLEN), .ONEHOT_MUX(ONEHOT_MUX)) u_sel (
         .hits   (hits[s]),
         .ex_val (ex_result),
         .mem_val(mem_result),
         .wb_val (wb_result),
         .rf_val (rf_val[s]),
         .dout   (opnd[s]),
         .src    (opnd_src[s])
      );

      assign ex_hit[s] = hits[s][SRC_EX];

      always_comb begin
         // R7: an unused source always resolves to the register file
         p_unused_from_rf_r7: assert (src_use[s] || opnd_src[s] == SRC_RF);
      end
   end

   assign opnd1 = opnd[0];
   assign opnd2 = opnd[1];

   dbp_interlock u_lock (
      .ex_hit      (ex_hit),
      .ex_is_load  (ex_is_load),
      .id_is_branch(id_is_branch),
      .ready_go    (id_ready_go),
      .br_stall    (br_stall)
   );
endmodule

// File: tb/decode_bypass_bench.sv
module decode_bypass_bench;
   localparam int XLEN = 32;
   localparam int AW   = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;   // 200 MHz

   logic [AW-1:0]   rs1_idx, rs2_idx, ex_dest, mem_dest, wb_dest;
   logic            rs1_use, rs2_use, id_is_branch;
   logic            ex_valid, ex_wen, ex_is_load, mem_valid, mem_wen, wb_valid, wb_wen;
   logic [XLEN-1:0] rf_rdata1, rf_rdata2, ex_result, mem_result, wb_result;
   logic [XLEN-1:0] opnd1, opnd2;
   logic            id_ready_go, br_stall;

   int checks = 0;
   int errors = 0;

   localparam logic [XLEN-1:0] V_RF1 = 32'h1111_0001;
   localparam logic [XLEN-1:0] V_RF2 = 32'h2222_0002;
   localparam logic [XLEN-1:0] V_EX  = 32'hEEEE_0003;
   localparam logic [XLEN-1:0] V_MEM = 32'hAAAA_0004;
   localparam logic [XLEN-1:0] V_WB  = 32'hBBBB_0005;

   decode_bypass #(.XLEN(XLEN), .AW(AW)) u_decode_bypass (
      .rs1_idx(rs1_idx), .rs1_use(rs1_use), .rs2_idx(rs2_idx), .rs2_use(rs2_use),
      .rf_rdata1(rf_rdata1), .rf_rdata2(rf_rdata2), .id_is_branch(id_is_branch),
      .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
      .ex_dest(ex_dest), .ex_result(ex_result),
      .mem_valid(mem_valid), .mem_wen(mem_wen), .mem_dest(mem_dest), .mem_result(mem_result),
      .wb_valid(wb_valid), .wb_wen(wb_wen), .wb_dest(wb_dest), .wb_result(wb_result),
      .opnd1(opnd1), .opnd2(opnd2), .id_ready_go(id_ready_go), .br_stall(br_stall)
   );

   task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // inputs change after the falling edge; outputs sampled just before the rising edge
   task automatic idle();
      @(negedge clk);
      rs1_idx = 5'd1; rs1_use = 1'b1; rs2_idx = 5'd2; rs2_use = 1'b1;
      rf_rdata1 = V_RF1; rf_rdata2 = V_RF2; id_is_branch = 1'b0;
      ex_valid = 1'b0; ex_wen = 1'b0; ex_is_load = 1'b0; ex_dest = 5'd0; ex_result = V_EX;
      mem_valid = 1'b0; mem_wen = 1'b0; mem_dest = 5'd0; mem_result = V_MEM;
      wb_valid = 1'b0; wb_wen = 1'b0; wb_dest = 5'd0; wb_result = V_WB;
   endtask

   task automatic settle();
      #1.5;
   endtask

   task automatic t_reset_state();
      idle(); settle();
      chk("R1 idle opnd1", opnd1, V_RF1);
      chk("R1 idle opnd2", opnd2, V_RF2);
      chk("R8 idle ready_go", {31'd0, id_ready_go}, 32'd1);
      chk("R9 idle br_stall", {31'd0, br_stall}, 32'd0);
   endtask

   task automatic t_passthru_r1();
      idle();
      ex_valid = 1; ex_wen = 1; ex_dest = 5'd7;
      mem_valid = 1; mem_wen = 1; mem_dest = 5'd8;
      wb_valid = 1; wb_wen = 1; wb_dest = 5'd9;
      settle();
      chk("R1 other dests opnd1", opnd1, V_RF1);
      chk("R1 other dests opnd2", opnd2, V_RF2);
   endtask

   task automatic t_ex_priority_r2();
      idle();
      rs1_idx = 5'd4;
      ex_valid = 1; ex_wen = 1; ex_dest = 5'd4;
      mem_valid = 1; mem_wen = 1; mem_dest = 5'd4;
      wb_valid = 1; wb_wen = 1; wb_dest = 5'd4;
      settle();
      chk("R2 ex over all", opnd1, V_EX);
      chk("R2 opnd2 untouched", opnd2, V_RF2);
      chk("R2 no stall on alu", {31'd0, id_ready_go}, 32'd1);
   endtask

   task automatic t_mem_over_wb_r3();
      idle();
      rs2_idx = 5'd12;
      mem_valid = 1; mem_wen = 1; mem_dest = 5'd12;
      wb_valid = 1; wb_wen = 1; wb_dest = 5'd12;
      settle();
      chk("R3 mem over wb", opnd2, V_MEM);
   endtask

   task automatic t_wb_only_r4();
      idle();
      rs1_idx = 5'd31;
      wb_valid = 1; wb_wen = 1; wb_dest = 5'd31;
      settle();
      chk("R4 wb only", opnd1, V_WB);
   endtask

   task automatic t_zero_reg_r5();
      idle();
      rs1_idx = 5'd0; rs2_idx = 5'd0;
      ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_dest = 5'd0;
      mem_valid = 1; mem_wen = 1; mem_dest = 5'd0;
      wb_valid = 1; wb_wen = 1; wb_dest = 5'd0;
      settle();
      chk("R5 x0 opnd1", opnd1, V_RF1);
      chk("R5 x0 opnd2", opnd2, V_RF2);
      chk("R5 x0 no stall", {31'd0, id_ready_go}, 32'd1);
   endtask

   task automatic t_dead_stage_r6();
      idle();
      rs1_idx = 5'd6; rs2_idx = 5'd6;
      ex_valid = 0; ex_wen = 1; ex_is_load = 1; ex_dest = 5'd6;
      mem_valid = 1; mem_wen = 0; mem_dest = 5'd6;
      wb_valid = 0; wb_wen = 1; wb_dest = 5'd6;
      settle();
      chk("R6 dead stages opnd1", opnd1, V_RF1);
      chk("R6 dead stages opnd2", opnd2, V_RF2);
      chk("R6 invalid load no stall", {31'd0, id_ready_go}, 32'd1);
      ex_valid = 1; ex_wen = 0;
      settle();
      chk("R6 non-writing load no stall", {31'd0, id_ready_go}, 32'd1);
      chk("R6 non-writing ex opnd1", opnd1, V_RF1);
   endtask

   task automatic t_unused_r7();
      idle();
      rs1_idx = 5'd3; rs1_use = 0; rs2_idx = 5'd3; rs2_use = 0;
      ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_dest = 5'd3;
      settle();
      chk("R7 unused opnd1", opnd1, V_RF1);
      chk("R7 unused opnd2", opnd2, V_RF2);
      chk("R7 unused no stall", {31'd0, id_ready_go}, 32'd1);
   endtask

   task automatic t_load_use_r8();
      idle();
      rs2_idx = 5'd10;
      ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_dest = 5'd10;
      settle();
      chk("R8 load in ex stalls", {31'd0, id_ready_go}, 32'd0);
      chk("R8 non-branch no br_stall", {31'd0, br_stall}, 32'd0);
      ex_dest = 5'd11;
      settle();
      chk("R8 unrelated load no stall", {31'd0, id_ready_go}, 32'd1);
      idle();
      rs2_idx = 5'd10;
      mem_valid = 1; mem_wen = 1; mem_dest = 5'd10;
      settle();
      chk("R8 load in mem forwards", opnd2, V_MEM);
      chk("R8 load in mem no stall", {31'd0, id_ready_go}, 32'd1);
   endtask

   task automatic t_branch_r9();
      idle();
      id_is_branch = 1; rs1_idx = 5'd13;
      ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_dest = 5'd13;
      settle();
      chk("R9 stalled branch ready_go", {31'd0, id_ready_go}, 32'd0);
      chk("R9 stalled branch br_stall", {31'd0, br_stall}, 32'd1);
      ex_is_load = 0;
      settle();
      chk("R9 alu producer no br_stall", {31'd0, br_stall}, 32'd0);
      chk("R9 branch gets ex value", opnd1, V_EX);
   endtask

   task automatic t_split_r10();
      idle();
      rs1_idx = 5'd20; rs2_idx = 5'd21;
      ex_valid = 1; ex_wen = 1; ex_dest = 5'd20;
      wb_valid = 1; wb_wen = 1; wb_dest = 5'd21;
      settle();
      chk("R10 opnd1 from ex", opnd1, V_EX);
      chk("R10 opnd2 from wb", opnd2, V_WB);
      idle();
      rs1_idx = 5'd15; rs2_idx = 5'd15;
      mem_valid = 1; mem_wen = 1; mem_dest = 5'd15;
      settle();
      chk("R10 both from mem opnd1", opnd1, V_MEM);
      chk("R10 both from mem opnd2", opnd2, V_MEM);
   endtask

   initial begin : watchdog
      #100000;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_reset_state();
      t_passthru_r1();
      t_ex_priority_r2();
      t_mem_over_wb_r3();
      t_wb_only_r4();
      t_zero_reg_r5();
      t_dead_stage_r6();
      t_unused_r7();
      t_load_use_r8();
      t_branch_r9();
      t_split_r10();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule